// File: doc/BRIEF.md
# Banked Stack Pointer Register File

This block holds the four physical stack pointers of a core that runs in a secure and a non-secure state, along with one lower-bound limit register for each pointer. A pipeline sees one logical stack pointer, `sp_out`. The physical copy behind it is chosen by the current security state, by handler versus thread mode, and, in thread mode, by a stack-select bit that each security state owns.

The stack-operation port performs one operation per cycle on the active copy: a write, a push (decrement) or a pop (increment). Each copy has its own comparator, which checks the candidate value against that copy's limit. A move that would go below the limit is dropped, and a one-cycle fault pulse is raised instead. A separate register-access port gives direct reads and writes of every pointer and limit. Privilege gates this port. Secure privileged code can also reach the non-secure copies through an alias bit.

Top module: `stkptr_bank`

## Requirements
- R1: After reset all four pointers and all four limits read as zero, `sp_out` is zero and `ovf_pulse` is low.
- R2: In handler mode (`handler_mode`=1) the active copy is the main pointer of the current security state, whatever the stack-select bits hold.
- R3: In thread mode the active copy is the process pointer when the current state's own select bit is 1 (`stk_sel_sec` when `cur_secure`=1, `stk_sel_nsec` otherwise), and the main pointer when it is 0.
- R4: `op_kind` encodes 0 = none, 1 = write `op_wdata`, 2 = push (subtract `op_amt`), 3 = pop (add `op_amt`). Bits [2:0] of `op_amt` and `op_wdata` are ignored, so every stored pointer keeps bits [2:0] at zero. The new value shows on `sp_out` after the clock edge.
- R5: If the new value of the active copy is below that copy's limit, or a push would wrap below zero, the pointer keeps its value and `ovf_pulse` is high for exactly the one cycle that follows the operation.
- R6: A new value equal to the limit is accepted and raises no pulse.
- R7: Direct-access encoding: `ra_lim`=1 selects a limit and 0 selects a pointer. `ra_proc`=1 selects the process copy and 0 the main copy. `ra_alias`=1 from the secure state targets the non-secure bank. Otherwise the current state's bank is targeted. Read data is combinational. Written data has bits [2:0] cleared.
- R8: Direct access is denied in unprivileged thread mode (`handler_mode`=0, `thread_unpriv`=1). Handler mode is always privileged. A denied access returns zero, leaves every register unchanged and drives `ra_err` high.
- R9: From the non-secure state, direct access with `ra_alias`=0 reaches the non-secure bank. With `ra_alias`=1 it is denied as in R8, so secure copies are never read or changed from the non-secure state.
- R10: When a direct write and a stack operation target the same pointer in one cycle, the direct write takes effect and the operation is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_secure | input | 1 | 1 = secure state is current |
| handler_mode | input | 1 | 1 = handler mode, 0 = thread mode |
| thread_unpriv | input | 1 | 1 = thread mode is unprivileged |
| stk_sel_sec | input | 1 | Secure-state stack select (1 = process) |
| stk_sel_nsec | input | 1 | Non-secure-state stack select (1 = process) |
| op_kind | input | 2 | Stack operation: 0 none, 1 write, 2 push, 3 pop |
| op_amt | input | AW | Byte amount for push/pop |
| op_wdata | input | AW | Value for the write operation |
| sp_out | output | AW | Active stack pointer |
| ovf_pulse | output | 1 | One-cycle limit-violation pulse |
| ra_en | input | 1 | Direct-access request |
| ra_we | input | 1 | Direct-access write enable |
| ra_lim | input | 1 | 1 = limit register, 0 = pointer |
| ra_proc | input | 1 | 1 = process copy, 0 = main copy |
| ra_alias | input | 1 | Target the non-secure bank from the secure state |
| ra_wdata | input | AW | Direct-access write data |
| ra_rdata | output | AW | Direct-access read data |
| ra_err | output | 1 | Direct access denied |

## Verification
The assertions assume that the mode and privilege inputs are stable within a cycle and are driven to known values from reset onward. They also assume that a non-secure state never asserts an operation that it intends for a secure copy. The bench holds `op_kind` at zero during reset and changes mode and stack-select bits only between operations. It brackets each direct access with `ra_en`, so every denied-access property sees a quiet operation port, except in the one collision scenario, which deliberately combines a permitted direct write with an operation.

// File: rtl/stkbank_pkg.sv
package stkbank_pkg;
   localparam int unsigned NCOPY = 4;   // {non_secure, process} index

   typedef enum logic [1:0] {
      SOP_NONE  = 2'd0,
      SOP_WRITE = 2'd1,
      SOP_PUSH  = 2'd2,
      SOP_POP   = 2'd3
   } sop_e;

   function automatic logic [1:0] copy_idx(input logic nsec, input logic proc);
      return {nsec, proc};
   endfunction
endpackage

// File: rtl/stkbank_select.sv
module stkbank_select
   import stkbank_pkg::*;
(
   input  logic       cur_secure,
   input  logic       handler_mode,
   input  logic       thread_unpriv,
   input  logic       stk_sel_sec,
   input  logic       stk_sel_nsec,
   input  logic       ra_en,
   input  logic       ra_alias,
   input  logic       ra_proc,
   output logic [1:0] act_idx,
   output logic [1:0] acc_idx,
   output logic       acc_deny
);
   logic act_proc;
   logic privileged;
   logic acc_nsec;

   // handler mode always uses the main copy of the current state
   assign act_proc   = !handler_mode && (cur_secure ? stk_sel_sec : stk_sel_nsec);
   assign act_idx    = copy_idx(!cur_secure, act_proc);

   assign privileged = handler_mode || !thread_unpriv;
   assign acc_nsec   = !cur_secure || ra_alias;
   assign acc_idx    = copy_idx(acc_nsec, ra_proc);
   // non-secure requesting the other bank is refused
   assign acc_deny   = ra_en && (!privileged || (!cur_secure && ra_alias));
endmodule

// File: rtl/stkbank_cmp.sv
module stkbank_cmp
   import stkbank_pkg::*;
#(
   parameter int unsigned AW  = 32,
   parameter int unsigned ALB = 3
) (
   input  logic [AW-1:0] cur_val,
   input  logic [AW-1:0] lim_val,
   input  logic [1:0]    op_kind,
   input  logic [AW-1:0] op_amt,
   input  logic [AW-1:0] op_wdata,
   output logic [AW-1:0] cand,
   output logic          ovf
);
   localparam logic [AW-1:0] MASK = {{(AW-ALB){1'b1}}, {ALB{1'b0}}};

   logic [AW-1:0] amt_al;
   logic [AW-1:0] wd_al;
   logic          wrap;

   assign amt_al = op_amt & MASK;
   assign wd_al  = op_wdata & MASK;

   always_comb begin
      cand = cur_val;
      wrap = 1'b0;
      unique case (sop_e'(op_kind))
         SOP_WRITE: cand = wd_al;
         SOP_PUSH: begin
            cand = cur_val - amt_al;
            wrap = cur_val < amt_al;
         end
         SOP_POP:   cand = cur_val + amt_al;
         default:   cand = cur_val;
      endcase
   end

   assign ovf = (sop_e'(op_kind) != SOP_NONE) && (wrap || (cand < lim_val));
endmodule

// File: rtl/stkbank_regs.sv
module stkbank_regs
   import stkbank_pkg::*;
#(
   parameter int unsigned AW  = 32,
   parameter int unsigned ALB = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NCOPY-1:0]           upd_vec,
   input  logic [NCOPY-1:0][AW-1:0]   cand_vec,
   input  logic [NCOPY-1:0]           wr_sp_vec,
   input  logic [NCOPY-1:0]           wr_lim_vec,
   input  logic [AW-1:0]              wdata,
   output logic [NCOPY-1:0][AW-1:0]   sp_q,
   output logic [NCOPY-1:0][AW-1:0]   lim_q
);
   localparam logic [AW-1:0] MASK = {{(AW-ALB){1'b1}}, {ALB{1'b0}}};

   for (genvar g = 0; g < NCOPY; g++) begin : g_copy
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sp_q[g]  <= '0;
            lim_q[g] <= '0;
         end else begin
            if (wr_sp_vec[g])     sp_q[g] <= wdata & MASK;   // direct write wins (R10)
            else if (upd_vec[g])  sp_q[g] <= cand_vec[g];
            if (wr_lim_vec[g])    lim_q[g] <= wdata & MASK;
         end
      end

      // R4: stored pointers and limits stay 8-byte aligned
      p_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (sp_q[g][ALB-1:0] == '0) && (lim_q[g][ALB-1:0] == '0));
   end

   // R8: a limit changes only through a permitted direct write
   p_lim_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lim_vec == '0) |=> $stable(lim_q));
endmodule

// File: rtl/stkptr_bank.sv
module stkptr_bank
   import stkbank_pkg::*;
#(
   parameter int unsigned AW  = 32,
   parameter int unsigned ALB = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cur_secure,
   input  logic          handler_mode,
   input  logic          thread_unpriv,
   input  logic          stk_sel_sec,
   input  logic          stk_sel_nsec,
   input  logic [1:0]    op_kind,
   input  logic [AW-1:0] op_amt,
   input  logic [AW-1:0] op_wdata,
   output logic [AW-1:0] sp_out,
   output logic          ovf_pulse,
   input  logic          ra_en,
   input  logic          ra_we,
   input  logic          ra_lim,
   input  logic          ra_proc,
   input  logic          ra_alias,
   input  logic [AW-1:0] ra_wdata,
   output logic [AW-1:0] ra_rdata,
   output logic          ra_err
);
   if (ALB >= AW) begin : g_bad_align
      $error("stkptr_bank: ALB must be smaller than AW");
   end
   if (AW < 8) begin : g_bad_width
      $error("stkptr_bank: AW must be at least 8");
   end

   logic [1:0]                act_idx;
   logic [1:0]                acc_idx;
   logic                      acc_deny;
   logic [NCOPY-1:0][AW-1:0]  sp_q;
   logic [NCOPY-1:0][AW-1:0]  lim_q;
   logic [NCOPY-1:0][AW-1:0]  cand_vec;
   logic [NCOPY-1:0]          ovf_vec;
   logic [NCOPY-1:0]          upd_vec;
   logic [NCOPY-1:0]          wr_sp_vec;
   logic [NCOPY-1:0]          wr_lim_vec;
   logic                      op_active;
   logic                      ra_ok;
   logic                      sel_ovf;
   logic                      ovf_q;

   stkbank_select u_sel (
      .cur_secure   (cur_secure),
      .handler_mode (handler_mode),
      .thread_unpriv(thread_unpriv),
      .stk_sel_sec  (stk_sel_sec),
      .stk_sel_nsec (stk_sel_nsec),
      .ra_en        (ra_en),
      .ra_alias     (ra_alias),
      .ra_proc      (ra_proc),
      .act_idx      (act_idx),
      .acc_idx      (acc_idx),
      .acc_deny     (acc_deny)
   );

   assign op_active = sop_e'(op_kind) != SOP_NONE;
   assign ra_ok     = ra_en && !acc_deny;

   for (genvar g = 0; g < NCOPY; g++) begin : g_lane
      stkbank_cmp #(.AW(AW), .ALB(ALB)) u_cmp (
         .cur_val (sp_q[g]),
         .lim_val (lim_q[g]),
         .op_kind (op_kind),
         .op_amt  (op_amt),
         .op_wdata(op_wdata),
         .cand    (cand_vec[g]),
         .ovf     (ovf_vec[g])
      );
      assign upd_vec[g]    = op_active && (act_idx == 2'(g)) && !ovf_vec[g];
      assign wr_sp_vec[g]  = ra_ok && ra_we && !ra_lim && (acc_idx == 2'(g));
      assign wr_lim_vec[g] = ra_ok && ra_we &&  ra_lim && (acc_idx == 2'(g));
   end

   stkbank_regs #(.AW(AW), .ALB(ALB)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .upd_vec   (upd_vec),
      .cand_vec  (cand_vec),
      .wr_sp_vec (wr_sp_vec),
      .wr_lim_vec(wr_lim_vec),
      .wdata     (ra_wdata),
      .sp_q      (sp_q),
      .lim_q     (lim_q)
   );

   assign sel_ovf = op_active && ovf_vec[act_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) ovf_q <= 1'b0;
      else        ovf_q <= sel_ovf;
   end

   assign ovf_pulse = ovf_q;
   assign sp_out    = sp_q[act_idx];
   assign ra_rdata  = ra_ok ? (ra_lim ? lim_q[acc_idx] : sp_q[acc_idx]) : '0;
   assign ra_err    = acc_deny;

   // R5: a refused move leaves every pointer untouched
   p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_ovf && (wr_sp_vec == '0)) |=> $stable(sp_q));

   // R5: the pulse only follows an operation
   p_pulse_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |-> $past(op_kind != 2'd0));

   // R2: handler-mode operations never move a process copy
   p_handler_main_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (handler_mode && !ra_en) |=> ($stable(sp_q[1]) && $stable(sp_q[3])));

   // R8: a denied access with a quiet operation port changes nothing
   p_deny_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_deny && !op_active) |=> ($stable(sp_q) && $stable(lim_q)));

   // R9: the non-secure state never alters a secure copy
   p_nsec_isolate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cur_secure |=> ($stable(sp_q[0]) && $stable(sp_q[1]) &&
                       $stable(lim_q[0]) && $stable(lim_q[1])));
endmodule

// File: tb/tb_stkptr_bank.sv
module tb_stkptr_bank;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cur_secure, handler_mode, thread_unpriv, stk_sel_sec, stk_sel_nsec;
   logic [1:0]    op_kind;
   logic [AW-1:0] op_amt, op_wdata;
   logic [AW-1:0] sp_out;
   logic          ovf_pulse;
   logic          ra_en, ra_we, ra_lim, ra_proc, ra_alias;
   logic [AW-1:0] ra_wdata, ra_rdata;
   logic          ra_err;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4ns clk = ~clk;   // 125 MHz

   stkptr_bank #(.AW(AW), .ALB(3)) dut (.*);

   task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1ns;
   endtask

   task automatic set_mode(input logic sec, input logic hnd, input logic unp,
                           input logic sel_s, input logic sel_n);
      cur_secure = sec; handler_mode = hnd; thread_unpriv = unp;
      stk_sel_sec = sel_s; stk_sel_nsec = sel_n;
      #1ns;
   endtask

   task automatic dwr(input logic alias_b, input logic lim, input logic proc, input logic [AW-1:0] d);
      ra_en = 1; ra_we = 1; ra_alias = alias_b; ra_lim = lim; ra_proc = proc; ra_wdata = d;
      tick();
      ra_en = 0; ra_we = 0; ra_alias = 0; ra_lim = 0; ra_proc = 0; ra_wdata = '0;
   endtask

   task automatic drd(input logic alias_b, input logic lim, input logic proc,
                      output logic [AW-1:0] d, output logic e);
      ra_en = 1; ra_we = 0; ra_alias = alias_b; ra_lim = lim; ra_proc = proc;
      #1ns;
      d = ra_rdata; e = ra_err;
      ra_en = 0; ra_alias = 0; ra_lim = 0; ra_proc = 0;
      #1ns;
   endtask

   task automatic sop(input logic [1:0] k, input logic [AW-1:0] amt, input logic [AW-1:0] wd);
      op_kind = k; op_amt = amt; op_wdata = wd;
      tick();
      op_kind = 2'd0; op_amt = '0; op_wdata = '0;
   endtask

   task automatic t_reset();
      logic [AW-1:0] d; logic e;
      set_mode(1, 0, 0, 0, 0);
      chk("R1 sp_out", sp_out, '0);
      chk("R1 ovf_pulse", {31'd0, ovf_pulse}, 32'd0);
      for (int i = 0; i < 8; i++) begin
         drd(i[2], i[1], i[0], d, e);
         chk("R1 register", d, '0);
      end
   endtask

   task automatic t_select();
      logic [AW-1:0] d; logic e;
      dwr(0, 0, 0, 32'h1000);
      dwr(0, 0, 1, 32'h2007);
      dwr(1, 0, 0, 32'h3000);
      dwr(1, 0, 1, 32'h4000);
      drd(0, 0, 1, d, e);
      chk("R7 aligned direct write", d, 32'h2000);
      drd(1, 0, 0, d, e);
      chk("R7 alias read", d, 32'h3000);
      set_mode(1, 0, 0, 0, 1);
      chk("R3 secure thread main", sp_out, 32'h1000);
      set_mode(1, 0, 0, 1, 0);
      chk("R3 secure thread process", sp_out, 32'h2000);
      set_mode(1, 1, 0, 1, 1);
      chk("R2 secure handler main", sp_out, 32'h1000);
      set_mode(0, 0, 0, 0, 1);
      chk("R3 nonsecure thread process", sp_out, 32'h4000);
      set_mode(0, 1, 0, 1, 1);
      chk("R2 nonsecure handler main", sp_out, 32'h3000);
   endtask

   task automatic t_ops();
      set_mode(1, 0, 0, 0, 0);
      sop(2'd2, 32'h20, '0);
      chk("R4 push", sp_out, 32'h0FE0);
      sop(2'd2, 32'h27, '0);
      chk("R4 push amount low bits ignored", sp_out, 32'h0FC0);
      sop(2'd3, 32'h10, '0);
      chk("R4 pop", sp_out, 32'h0FD0);
      sop(2'd1, '0, 32'h1237);
      chk("R4 write aligned", sp_out, 32'h1230);
      chk("R4 no pulse", {31'd0, ovf_pulse}, 32'd0);
   endtask

   task automatic t_limit();
      dwr(0, 1, 0, 32'h1200);
      sop(2'd2, 32'h30, '0);
      chk("R6 equal to limit accepted", sp_out, 32'h1200);
      chk("R6 no pulse at limit", {31'd0, ovf_pulse}, 32'd0);
      sop(2'd2, 32'h8, '0);
      chk("R5 push below limit held", sp_out, 32'h1200);
      chk("R5 pulse raised", {31'd0, ovf_pulse}, 32'd1);
      tick();
      chk("R5 pulse one cycle", {31'd0, ovf_pulse}, 32'd0);
      sop(2'd1, '0, 32'h100);
      chk("R5 write below limit held", sp_out, 32'h1200);
      chk("R5 write pulse", {31'd0, ovf_pulse}, 32'd1);
      set_mode(1, 0, 0, 1, 0);
      sop(2'd2, 32'h3000, '0);
      chk("R5 push wrap held", sp_out, 32'h2000);
      chk("R5 wrap pulse", {31'd0, ovf_pulse}, 32'd1);
      tick();
   endtask

   task automatic t_priv();
      logic [AW-1:0] d; logic e;
      set_mode(1, 0, 1, 0, 0);
      drd(0, 0, 0, d, e);
      chk("R8 unpriv read zero", d, '0);
      chk("R8 unpriv err", {31'd0, e}, 32'd1);
      dwr(0, 1, 0, 32'hFFF8);
      set_mode(1, 1, 1, 0, 0);
      drd(0, 1, 0, d, e);
      chk("R8 denied write ignored", d, 32'h1200);
      chk("R8 handler privileged", {31'd0, e}, 32'd0);
   endtask

   task automatic t_nsec();
      logic [AW-1:0] d; logic e;
      set_mode(0, 0, 0, 0, 0);
      drd(0, 0, 0, d, e);
      chk("R9 nonsecure own bank", d, 32'h3000);
      drd(1, 0, 0, d, e);
      chk("R9 alias read zero", d, '0);
      chk("R9 alias err", {31'd0, e}, 32'd1);
      dwr(1, 0, 1, 32'h5550);
      dwr(0, 1, 0, 32'h100);
      set_mode(1, 0, 0, 0, 0);
      drd(0, 0, 1, d, e);
      chk("R9 secure copy untouched", d, 32'h2000);
      drd(1, 1, 0, d, e);
      chk("R9 nonsecure own limit write", d, 32'h100);
   endtask

   task automatic t_collide();
      set_mode(1, 0, 0, 0, 0);
      dwr(0, 1, 0, '0);
      op_kind = 2'd2; op_amt = 32'h10;
      ra_en = 1; ra_we = 1; ra_lim = 0; ra_proc = 0; ra_alias = 0; ra_wdata = 32'h800;
      tick();
      op_kind = 2'd0; op_amt = '0; ra_en = 0; ra_we = 0; ra_wdata = '0;
      chk("R10 direct write wins", sp_out, 32'h800);
   endtask

   initial begin
      rst_n = 0;
      cur_secure = 1; handler_mode = 0; thread_unpriv = 0; stk_sel_sec = 0; stk_sel_nsec = 0;
      op_kind = '0; op_amt = '0; op_wdata = '0;
      ra_en = 0; ra_we = 0; ra_lim = 0; ra_proc = 0; ra_alias = 0; ra_wdata = '0;
      repeat (3) tick();
      rst_n = 1;
      tick();
      t_reset();
      t_select();
      t_ops();
      t_limit();
      t_priv();
      t_nsec();
      t_collide();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      #800us;
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule